// File: doc/BRIEF.md
# Parity-Checked Video Lane Deserializer

This block rebuilds parallel video words from a serial link. The recovered bits arrive on one, two or three lanes at the bit clock. The block packs each 30-bit frame into one shift register. The frame holds 24 pixel bits and 3 control bits, which the block treats as a single 27-bit word. It also holds one even-parity bit and two fixed framing bits.

A word reaches the output bus only if its parity and framing both check out. If a check fails, the frame is dropped. The bus then shows the last good word for one more word slot, and an error flag pulses in that same cycle. A swap control mirrors the bit order of the output bus, which eases board routing.

Input stream rules: `in_valid` marks each beat and `frame_start` marks the first beat of a frame. There is no ready signal, so the block takes every valid beat and never stalls the source. The source may leave gaps by holding `in_valid` low. Output stream rules: `word_valid` is a one-cycle strobe with no back-pressure, so the consumer must take the word in that cycle.

Top module: `lane_frame_deser`

## Requirements
- R1: After reset, `word_o` is zero and `word_valid` and `par_err` are low. They stay so until a complete frame has been received.
- R2: The frame is sent in slot order s0..s29. s0 is 1 and s1 is 0 (framing). Slots s2..s28 carry data bits d0..d26, and d0 maps to `word_o[0]` when unswapped. Slot s29 is parity, and the 27 data bits plus parity hold an even number of ones.
- R3: `lane_cfg` gives the lane count N (values 1, 2 or 3; value 0 acts as 1). On beat k, lane l (`lane_bits[l]`) carries slot k*N+l. A frame therefore takes 30, 15 or 10 beats. Lanes at or above N are ignored. `lane_cfg` changes only while in reset.
- R4: For a frame that passes both checks, `word_o` takes the new data and `word_valid` pulses for one cycle with `par_err` low. Timing: the frame's last beat is sampled at edge E, and the pulse occupies the cycle after edge E+1.
- R5: For a frame with bad parity, `par_err` and `word_valid` pulse together for one cycle and `word_o` keeps the previous good word.
- R6: For a frame whose framing slots are not 1 then 0, the block behaves exactly as for a parity failure.
- R7: When `swap_en` is 1, `word_o[i]` shows stored bit 26-i. The swap acts at once and does not alter the stored word.
- R8: A beat with `frame_start` high always begins a new frame, and any partial frame is discarded.
- R9: Beats with `in_valid` low are not counted. Valid beats without `frame_start` are ignored while no frame is in progress.
- R10: After an error, the next good frame updates the word normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_cfg | input | 2 | Number of active lanes |
| swap_en | input | 1 | Mirror output bit order |
| in_valid | input | 1 | Beat carries lane bits |
| frame_start | input | 1 | First beat of a frame |
| lane_bits | input | 3 | One serial bit per lane |
| word_o | output | 27 | Pixel and control word |
| word_valid | output | 1 | One-cycle word strobe |
| par_err | output | 1 | One-cycle frame error pulse |

## Verification
The embedded assertions check four things on every cycle:
- the error pulse lasts one cycle and always comes with a word strobe;
- the word is unchanged whenever an error is flagged;
- every strobe follows a completed frame;
- the beat counter stays within the frame length.

The bench scenarios cover what needs chosen data:
- the slot-to-lane mapping under each lane count;
- the polarity of the parity and framing checks;
- the mirror produced by swap;
- the restart on a mid-frame `frame_start`;
- tolerance of gaps in the input.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
  localparam int FRAME_W   = 30;
  localparam int DATA_W    = 27;
  localparam int MAX_LANES = 3;
  localparam int CNT_W     = $clog2(FRAME_W + 1);

  function automatic int lanes_of(input logic [1:0] cfg);
    return (cfg == 2'd0) ? 1 : int'(cfg);
  endfunction
endpackage

// File: rtl/lfd_shifter.sv
module lfd_shifter
  import lfd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int NL = MAX_LANES,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lane_cfg,
  input  logic [NL-1:0] lanes,
  input  logic          beat_valid,
  input  logic          beat_first,
  output logic [FW-1:0] frame_o,
  output logic          done_o
);
  logic [FW-1:0]    sr_q;
  logic [FW+NL-1:0] ext;
  logic [FW-1:0]    sr_nxt;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    beats;
  logic [CW-1:0]    cnt_nxt;
  logic             take;

  always_comb begin
    beats   = CW'(FW / lanes_of(lane_cfg));
    ext     = {lanes, sr_q} >> lanes_of(lane_cfg);
    sr_nxt  = ext[FW-1:0];
    take    = beat_valid && (beat_first || cnt_q != '0);
    cnt_nxt = beat_first ? CW'(1) : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take) begin
        sr_q <= sr_nxt;
        if (cnt_nxt == beats) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign frame_o = sr_q;

  AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < beats); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
endmodule

// File: rtl/lfd_check.sv
module lfd_check
  import lfd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] frame_i,
  input  logic          done_i,
  output logic [DW-1:0] word_q,
  output logic          valid_q,
  output logic          err_q
);
  logic frame_ok;

  always_comb begin
    frame_ok = frame_i[0] && !frame_i[1] && !(^frame_i[FW-1:2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= done_i;
      err_q   <= done_i && !frame_ok;
      if (done_i && frame_ok) word_q <= frame_i[DW+1:2];
    end
  end

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q); // R5
  AST_ERR_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> valid_q); // R5
  AST_ERR_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(word_q)); // R5
  AST_STROBE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(done_i)); // R4
endmodule

// File: rtl/lane_frame_deser.sv
module lane_frame_deser
  import lfd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int DW = DATA_W,
  parameter int NL = MAX_LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lane_cfg,
  input  logic          swap_en,
  input  logic          in_valid,
  input  logic          frame_start,
  input  logic [NL-1:0] lane_bits,
  output logic [DW-1:0] word_o,
  output logic          word_valid,
  output logic          par_err
);
  logic [FW-1:0] frame;
  logic          done;
  logic [DW-1:0] word_q;

  lfd_shifter #(.FW(FW), .NL(NL), .CW($clog2(FW + 1))) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_cfg   (lane_cfg),
    .lanes      (lane_bits),
    .beat_valid (in_valid),
    .beat_first (frame_start),
    .frame_o    (frame),
    .done_o     (done)
  );

  lfd_check #(.FW(FW), .DW(DW)) u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame),
    .done_i  (done),
    .word_q  (word_q),
    .valid_q (word_valid),
    .err_q   (par_err)
  );

  for (genvar i = 0; i < DW; i++) begin : g_swap
    assign word_o[i] = swap_en ? word_q[DW-1-i] : word_q[i];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!word_valid && !par_err)); // R1
endmodule

// File: tb/lane_frame_deser_tb.sv
module lane_frame_deser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lane_cfg = 2'd1;
  logic        swap_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        frame_start = 1'b0;
  logic [2:0]  lane_bits = '0;
  logic [26:0] word_o;
  logic        word_valid;
  logic        par_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lane_frame_deser u_dut (
    .clk(clk), .rst_n(rst_n), .lane_cfg(lane_cfg), .swap_en(swap_en),
    .in_valid(in_valid), .frame_start(frame_start), .lane_bits(lane_bits),
    .word_o(word_o), .word_valid(word_valid), .par_err(par_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] mirror(input logic [26:0] v);
    logic [26:0] r;
    for (int i = 0; i < 27; i++) r[i] = v[26-i];
    return r;
  endfunction

  task automatic do_reset(input int nl);
    @(negedge clk);
    rst_n = 1'b0;
    lane_cfg = 2'(nl);
    in_valid = 1'b0;
    frame_start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Sends one frame; returns at the negedge after edge E+1 (R4 timing).
  task automatic send_frame(input logic [26:0] d, input int nl,
                            input bit bad_par, input bit bad_frm, input bit gaps);
    logic [29:0] s;
    int nb;
    s[0] = bad_frm ? 1'b0 : 1'b1;
    s[1] = 1'b0;
    s[28:2] = d;
    s[29] = (^d) ^ bad_par;
    nb = 30 / nl;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      lane_bits = 3'b111;
      for (int l = 0; l < nl; l++) lane_bits[l] = s[k*nl+l];
      in_valid = 1'b1;
      frame_start = (k == 0);
      if (gaps && k != 0) begin
        in_valid = 1'b0;
        frame_start = 1'b1;
        lane_bits = ~lane_bits;
        @(negedge clk);
        in_valid = 1'b1;
        frame_start = 1'b0;
        lane_bits = ~lane_bits;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 word after reset", 32'(word_o), 32'h0);
    chk("R1 strobe after reset", 32'(word_valid), 32'h0);
    chk("R1 err after reset", 32'(par_err), 32'h0);
  endtask

  task automatic t_lanes;
    logic [26:0] vals [3];
    vals[0] = 27'h5A5A5A5; vals[1] = 27'h1234567; vals[2] = 27'h7000001;
    for (int n = 1; n <= 3; n++) begin
      do_reset(n);
      send_frame(vals[n-1], n, 1'b0, 1'b0, 1'b0);
      chk($sformatf("R3 R2 word lanes=%0d", n), 32'(word_o), 32'(vals[n-1]));
      chk($sformatf("R4 strobe lanes=%0d", n), 32'(word_valid), 32'h1);
      chk($sformatf("R4 err low lanes=%0d", n), 32'(par_err), 32'h0);
      @(negedge clk);
      chk($sformatf("R4 strobe one cycle lanes=%0d", n), 32'(word_valid), 32'h0);
    end
  endtask

  task automatic t_parity;
    do_reset(2);
    send_frame(27'h00ABCDE, 2, 1'b0, 1'b0, 1'b0);
    send_frame(27'h7FFFFFF, 2, 1'b1, 1'b0, 1'b0);
    chk("R5 err pulse", 32'(par_err), 32'h1);
    chk("R5 strobe with err", 32'(word_valid), 32'h1);
    chk("R5 word held", 32'(word_o), 32'h00ABCDE);
    @(negedge clk);
    chk("R5 err one cycle", 32'(par_err), 32'h0);
    send_frame(27'h0F0F0F0, 2, 1'b0, 1'b0, 1'b0);
    chk("R10 word after error", 32'(word_o), 32'h0F0F0F0);
    chk("R10 err low", 32'(par_err), 32'h0);
  endtask

  task automatic t_framing;
    do_reset(3);
    send_frame(27'h2222222, 3, 1'b0, 1'b0, 1'b0);
    send_frame(27'h3333333, 3, 1'b0, 1'b1, 1'b0);
    chk("R6 err on framing", 32'(par_err), 32'h1);
    chk("R6 word held", 32'(word_o), 32'h2222222);
  endtask

  task automatic t_swap;
    do_reset(1);
    send_frame(27'h0000003, 1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    swap_en = 1'b1;
    #1;
    chk("R7 mirrored word", 32'(word_o), 32'(mirror(27'h0000003)));
    send_frame(27'h1234001, 1, 1'b0, 1'b0, 1'b0);
    chk("R7 mirrored new word", 32'(word_o), 32'(mirror(27'h1234001)));
    swap_en = 1'b0;
    #1;
    chk("R7 unswapped restore", 32'(word_o), 32'h1234001);
  endtask

  task automatic t_restart;
    do_reset(3);
    // beats without frame_start while idle must be ignored (R9)
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      in_valid = 1'b1; frame_start = 1'b0; lane_bits = 3'(k);
    end
    // partial frame, then restart (R8)
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; frame_start = (k == 0); lane_bits = 3'b101;
    end
    @(negedge clk);
    chk("R9 no strobe from stray beats", 32'(word_valid), 32'h0);
    send_frame(27'h4455667, 3, 1'b0, 1'b0, 1'b0);
    chk("R8 word after restart", 32'(word_o), 32'h4455667);
    chk("R8 err low after restart", 32'(par_err), 32'h0);
  endtask

  task automatic t_gaps;
    do_reset(2);
    send_frame(27'h6543210, 2, 1'b0, 1'b0, 1'b1);
    chk("R9 word with gaps", 32'(word_o), 32'h6543210);
    chk("R9 strobe with gaps", 32'(word_valid), 32'h1);
    chk("R9 err low with gaps", 32'(par_err), 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_parity();
    t_framing();
    t_swap();
    t_restart();
    t_gaps();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule